// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer that software controls through a single write port. Each write carries a run bit and a small key. The block reads every write against its current state and the key it has stored. A stopped watchdog ignores writes that leave the run bit clear, and any write with the run bit set starts it. A started watchdog only accepts a service, which is either a restart or a stop, when the written key is the bitwise inverse of the stored key. Any other write to a started watchdog replaces the stored key and does nothing else. Because the accepted key flips on every restart, a stray repeated write cannot keep the watchdog quiet.

Once started, the watchdog counts ticks on a separate tick input. If it is not serviced within a first window of ticks, it raises a non-maskable interrupt line. If the second, shorter window then also runs out without a service, it emits a chip reset pulse of fixed width and returns to the stopped state. Both windows and the pulse width are parameters. Simulation can therefore use short values, and silicon can use tick counts equal to 0.1 s and 3.3 ms.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is stopped, and both `nmi` and `chip_rst` are low.
- R2: While stopped, a write with `wr_run`=0 has no effect. Later ticks raise no `nmi`, and a following start behaves normally.
- R3: While stopped, a write with `wr_run`=1 starts the watchdog and stores `wr_key` as the key.
- R4: While started, a write with `wr_run`=0 and `wr_key` equal to the bitwise inverse of the stored key stops the watchdog and clears `nmi`. Ticks after that raise nothing.
- R5: While started, a write with `wr_run`=1 and `wr_key` equal to the inverse of the stored key restarts the first window and stores that inverted value as the new key.
- R6: While started, a write whose key is not the inverse of the stored key replaces the stored key, whatever `wr_run` is. It neither restarts the count nor clears a pending `nmi`.
- R7: Once the watchdog has counted FIRST_TICKS ticks (cycles with `tick`=1) since its last start or restart, `nmi` goes high on the clock edge that counts the last of them.
- R8: With `nmi` high, the watchdog counts SECOND_TICKS further ticks without a service. On the edge that counts the last of them, `chip_rst` rises, `nmi` falls and the watchdog returns to the stopped state.
- R9: Each `chip_rst` pulse stays high for exactly RST_WIDTH clock cycles.
- R10: A valid restart or stop clears `nmi` on the next edge.
- R11: A start, restart or stop write in the same cycle as `tick`=1 wins: that tick is not counted. A key-only write does not block the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe, one write per cycle |
| wr_run | input | 1 | Run bit of the write |
| wr_key | input | KEY_W | Key field of the write (default 3 bits) |
| tick | input | 1 | Time-base pulse; each high cycle is one tick |
| nmi | output | 1 | Non-maskable interrupt, level, high after the first window expires |
| chip_rst | output | 1 | Chip reset pulse, RST_WIDTH cycles wide |

## Verification
Directed sequences cover several cases. A full run to NMI checks the exact tick count. A key-only write during a pending NMI shows that a key change differs from a service. A chain of restarts with alternating keys shows that the key really inverts. A stop checks that the stop is final, and an unserviced run to reset measures the pulse width. Write-and-tick collisions show which event wins in a shared cycle. A random phase issues writes whose keys are biased toward the correct inverse, with a mix of run bits and sparse ticks. A cycle model restated from the requirements follows the random phase, so any wrong key acceptance or miscounted tick shows up as a mismatch on `nmi` or `chip_rst`.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  // Key that a started watchdog accepts for a service, given its stored key.
  function automatic logic [7:0] key_inverse(input logic [7:0] stored, input int unsigned width);
    logic [7:0] mask;
    mask = 8'((1 << width) - 1);
    return (~stored) & mask;
  endfunction

  // Counter width able to hold values 0..limit.
  function automatic int unsigned count_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/kwd_key_ctrl.sv
module kwd_key_ctrl #(
  parameter int unsigned KEY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_run,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             expire_ev,
  output logic             active,
  output logic [KEY_W-1:0] key_q,
  output logic             start_ev,
  output logic             restart_ev,
  output logic             stop_ev,
  output logic             rekey_ev
);
  import kwd_pkg::*;

  logic             active_q;
  logic             key_match;
  logic [7:0]       inv_wide;

  always_comb begin
    inv_wide  = key_inverse(8'(key_q), KEY_W);
    key_match = (wr_key == inv_wide[KEY_W-1:0]);
  end

  assign start_ev   = wr_en && !active_q && wr_run;
  assign restart_ev = wr_en &&  active_q && key_match && wr_run;
  assign stop_ev    = wr_en &&  active_q && key_match && !wr_run;
  assign rekey_ev   = wr_en &&  active_q && !key_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      key_q    <= '0;
    end else begin
      if (start_ev || restart_ev || rekey_ev)
        key_q <= wr_key;
      if (start_ev)
        active_q <= 1'b1;
      else if (stop_ev || expire_ev)
        active_q <= 1'b0;
    end
  end

  assign active = active_q;

endmodule

// File: rtl/kwd_stage_timer.sv
module kwd_stage_timer #(
  parameter int unsigned FIRST_TICKS  = 20,
  parameter int unsigned SECOND_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic service_ev,
  input  logic tick,
  output logic tick_ev,
  output logic nmi_set_ev,
  output logic expire_ev,
  output logic nmi
);
  import kwd_pkg::*;

  localparam int unsigned MAXT = (FIRST_TICKS > SECOND_TICKS) ? FIRST_TICKS : SECOND_TICKS;
  localparam int unsigned CW   = count_width(MAXT);
  localparam logic [CW-1:0] FIRST_LAST  = CW'(FIRST_TICKS - 1);
  localparam logic [CW-1:0] SECOND_LAST = CW'(SECOND_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          alert_q;

  assign tick_ev    = active && tick && !service_ev;
  assign nmi_set_ev = tick_ev && !alert_q && (cnt_q == FIRST_LAST);
  assign expire_ev  = tick_ev &&  alert_q && (cnt_q == SECOND_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alert_q <= 1'b0;
    end else if (service_ev || expire_ev) begin
      cnt_q   <= '0;
      alert_q <= 1'b0;
    end else if (nmi_set_ev) begin
      cnt_q   <= '0;
      alert_q <= 1'b1;
    end else if (tick_ev) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign nmi = alert_q;

endmodule

// File: rtl/kwd_rst_pulse.sv
module kwd_rst_pulse #(
  parameter int unsigned RST_WIDTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  import kwd_pkg::*;

  localparam int unsigned RW = count_width(RST_WIDTH);

  logic [RW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      left_q <= '0;
    else if (fire)
      left_q <= RW'(RST_WIDTH);
    else if (left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign pulse = (left_q != '0);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int unsigned KEY_W        = 3,
  parameter int unsigned FIRST_TICKS  = 20,
  parameter int unsigned SECOND_TICKS = 5,
  parameter int unsigned RST_WIDTH    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_run,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             tick,
  output logic             nmi,
  output logic             chip_rst
);

  logic             active;
  logic [KEY_W-1:0] key_q;
  logic             start_ev, restart_ev, stop_ev, rekey_ev;
  logic             service_ev;
  logic             tick_ev, nmi_set_ev, expire_ev;

  assign service_ev = start_ev || restart_ev || stop_ev;

  kwd_key_ctrl #(.KEY_W(KEY_W)) u_key (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_run(wr_run), .wr_key(wr_key),
    .expire_ev(expire_ev),
    .active(active), .key_q(key_q),
    .start_ev(start_ev), .restart_ev(restart_ev),
    .stop_ev(stop_ev), .rekey_ev(rekey_ev)
  );

  kwd_stage_timer #(.FIRST_TICKS(FIRST_TICKS), .SECOND_TICKS(SECOND_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .active(active), .service_ev(service_ev), .tick(tick),
    .tick_ev(tick_ev), .nmi_set_ev(nmi_set_ev), .expire_ev(expire_ev),
    .nmi(nmi)
  );

  kwd_rst_pulse #(.RST_WIDTH(RST_WIDTH)) u_pulse (
    .clk(clk), .rst_n(rst_n),
    .fire(expire_ev), .pulse(chip_rst)
  );

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int unsigned KEY_W     = 3,
  parameter int unsigned RST_WIDTH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_key_en,
  input logic             wr_run,
  input logic [KEY_W-1:0] wr_key,
  input logic             active,
  input logic [KEY_W-1:0] key_q,
  input logic             start_ev,
  input logic             restart_ev,
  input logic             stop_ev,
  input logic             rekey_ev,
  input logic             expire_ev,
  input logic             nmi,
  input logic             chip_rst
);

  int hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= 0;
    else        hi_cnt <= chip_rst ? hi_cnt + 1 : 0;
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |=> (!nmi && !chip_rst && !active));

  a_r2_idle_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key_en && !wr_run && !active) |=> !active);

  a_r3_start_stores_key: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (active && key_q == $past(wr_key)));

  a_r4_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!active && !nmi));

  a_r6_rekey_keeps_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    (rekey_ev && nmi && !expire_ev) |=> nmi);

  a_r8_reset_after_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_rst) |-> ($past(nmi) && !nmi && !active));

  a_r9_pulse_not_long: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> (hi_cnt < RST_WIDTH));

  a_r9_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_rst) |-> (hi_cnt == RST_WIDTH));

  a_r10_service_clears_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    restart_ev |=> !nmi);

  a_r5_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_ev, restart_ev, stop_ev, rekey_ev}));

endmodule

bind keyed_watchdog kwd_checker #(.KEY_W(KEY_W), .RST_WIDTH(RST_WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_key_en(wr_en), .wr_run(wr_run), .wr_key(wr_key),
  .active(active), .key_q(key_q),
  .start_ev(start_ev), .restart_ev(restart_ev),
  .stop_ev(stop_ev), .rekey_ev(rekey_ev),
  .expire_ev(expire_ev), .nmi(nmi), .chip_rst(chip_rst)
);

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
  localparam int KW = 3, FT = 20, ST = 5, RW = 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_run = 0, tick = 0;
  logic [KW-1:0] wr_key = '0;
  logic nmi, chip_rst;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit m_act, m_alert, m_nmi;
  int m_key, m_cnt, m_rst;

  always #2.5 clk = ~clk;

  keyed_watchdog #(.KEY_W(KW), .FIRST_TICKS(FT), .SECOND_TICKS(ST), .RST_WIDTH(RW))
    u_keyed_watchdog (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_run(wr_run),
                      .wr_key(wr_key), .tick(tick), .nmi(nmi), .chip_rst(chip_rst));

  function automatic int inv(input int k);
    return (~k) & ((1 << KW) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_act = 0; m_alert = 0; m_nmi = 0; m_key = 0; m_cnt = 0; m_rst = 0;
  endtask

  // restated from the requirements
  task automatic model_step(input bit we, input bit run, input int k, input bit tk);
    bit serviced = 0;
    if (m_rst > 0) m_rst--;
    if (we) begin
      if (!m_act) begin
        if (run) begin m_act = 1; m_key = k; m_cnt = 0; m_alert = 0; m_nmi = 0; serviced = 1; end
      end else if (k == inv(m_key)) begin
        serviced = 1; m_cnt = 0; m_alert = 0; m_nmi = 0;
        if (run) m_key = k; else m_act = 0;
      end else m_key = k;
    end
    if (m_act && tk && !serviced) begin
      if (!m_alert) begin
        if (m_cnt == FT - 1) begin m_alert = 1; m_nmi = 1; m_cnt = 0; end else m_cnt++;
      end else begin
        if (m_cnt == ST - 1) begin m_act = 0; m_alert = 0; m_nmi = 0; m_cnt = 0; m_rst = RW; end
        else m_cnt++;
      end
    end
  endtask

  task automatic cyc(input bit we, input bit run, input int k, input bit tk, input string req);
    wr_en = we; wr_run = run; wr_key = KW'(k); tick = tk;
    @(posedge clk);
    model_step(we, run, k, tk);
    @(negedge clk);
    wr_en = 0; tick = 0;
    chk(nmi == m_nmi, req, "nmi", int'(nmi), int'(m_nmi));
    chk(chip_rst == (m_rst > 0), req, "chip_rst", int'(chip_rst), int'(m_rst > 0));
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, req);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual 0 expected 1");
      summary();
    end
  end

  initial begin
    int hi;
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!nmi && !chip_rst, "R1", "outputs after reset", int'({nmi, chip_rst}), 0);
    ticks(FT + 2, "R1");

    // R2: idle write with run=0, then ticks
    cyc(1, 0, 3, 0, "R2");
    ticks(FT + 3, "R2");
    chk(nmi == 0, "R2", "nmi after ignored write", int'(nmi), 0);

    // R3 + R7: start with key 5, count to NMI
    cyc(1, 1, 5, 0, "R3");
    ticks(FT - 1, "R7");
    chk(nmi == 0, "R7", "nmi one tick early", int'(nmi), 0);
    cyc(0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 1, "R7");
    chk(nmi == 1, "R7", "nmi at FIRST_TICKS", int'(nmi), 1);

    // R6: key-only write with nmi pending
    cyc(1, 1, 1, 1, "R6");
    chk(nmi == 1, "R6", "nmi kept after rekey", int'(nmi), 1);
    // R5 + R10: restart with inverse of 1 (=6)
    cyc(1, 1, 6, 0, "R10");
    chk(nmi == 0, "R10", "nmi cleared by restart", int'(nmi), 0);
    // key now 6, so 6 again is a rekey; 1 is the service
    cyc(1, 1, 6, 0, "R5");
    cyc(1, 1, 1, 0, "R5");
    ticks(FT - 1, "R5");
    chk(nmi == 0, "R5", "restart reloaded window", int'(nmi), 0);

    // R11: restart collides with tick; tick not counted
    cyc(1, 1, 6, 1, "R11");
    ticks(FT - 1, "R11");
    chk(nmi == 0, "R11", "colliding tick not counted", int'(nmi), 0);
    cyc(0, 0, 0, 1, "R11");
    chk(nmi == 1, "R11", "nmi after full window", int'(nmi), 1);

    // R4: stop with inverse of 6 (=1)
    cyc(1, 0, 1, 0, "R4");
    chk(nmi == 0, "R4", "stop clears nmi", int'(nmi), 0);
    ticks(FT + ST + 2, "R4");
    chk(nmi == 0 && chip_rst == 0, "R4", "stopped stays quiet", int'({nmi, chip_rst}), 0);

    // R8 + R9: run to reset
    cyc(1, 1, 2, 0, "R8");
    ticks(FT + ST - 1, "R8");
    chk(chip_rst == 0, "R8", "no reset one tick early", int'(chip_rst), 0);
    cyc(0, 0, 0, 1, "R8");
    chk(chip_rst == 1 && nmi == 0, "R8", "reset rises, nmi drops", int'({chip_rst, nmi}), 2);
    hi = 1;
    while (chip_rst && hi < 20) begin cyc(0, 0, 0, 1, "R9"); if (chip_rst) hi++; end
    chk(hi == RW, "R9", "pulse width", hi, RW);
    ticks(FT + 2, "R8");
    chk(nmi == 0, "R8", "stopped after reset", int'(nmi), 0);

    // random phase against the model
    for (int i = 0; i < 6000; i++) begin
      int r, k;
      bit we, run, tk;
      r  = $urandom_range(0, 99);
      we = (r < 8);
      k  = ($urandom_range(0, 3) != 0) ? inv(m_key) : $urandom_range(0, (1 << KW) - 1);
      run = ($urandom_range(0, 5) != 0);
      tk = ($urandom_range(0, 2) == 0);
      cyc(we, run, k, tk, "R6");
    end

    done = 1;
    summary();
  end
endmodule